// File: doc/BRIEF.md
# Palette Colour Lookup Loader

This block holds a 256-entry colour lookup palette. Each entry has separate 8-bit red, green and blue fields. A CPU fills the palette through two registers in a 32-byte register window. The first register selects an entry. The second register takes colour bytes, and a small sequencer steers each byte into the red, then the green, then the blue field of the selected entry. After blue is stored, the entry number steps forward by one. A single byte write delivers one colour byte. A 32-bit write delivers four colour bytes, most significant byte first, all within one cycle.

The display side reads the palette through a separate lookup port. It presents an 8-bit pixel code and gets back a 24-bit RGB word one cycle later. Every write to the colour-data register also raises a one-cycle strobe, which tells the display logic to redraw the whole frame.

Top module: `clut_writer`

## Requirements
- R1: A write with `addr_i` = 0x00 targets the index register and a write with `addr_i` = 0x04 targets the colour-data register. A write to any other offset of the 5-bit window leaves the palette, the entry pointer and the sequencer unchanged.
- R2: An index-register write loads `wdata_i[7:0]` as the entry pointer and returns the sequencer to red, even when it arrives partway through an entry.
- R3: Successive colour bytes are stored into red, then green, then blue of the entry under the pointer.
- R4: Once a blue byte is stored, the pointer steps by one modulo 256 (0xFF is followed by 0x00) and the sequencer goes back to red.
- R5: With `size_i` = 0 a data write delivers the single byte `wdata_i[7:0]`. With `size_i` = 1 it delivers four bytes in the order `wdata_i[31:24]`, `[23:16]`, `[15:8]`, `[7:0]`, and each byte advances the sequencer as in R3 and R4.
- R6: `rdata_o` reads as zero at all times.
- R7: While `rst_ni` is low, every red, green and blue field is cleared to zero, the pointer is cleared to 0x00 and the sequencer returns to red.
- R8: `pal_dirty_o` is high for exactly the one cycle after each colour-data write. It stays low after index writes and after idle cycles.
- R9: `pix_rgb_o` gives {red, green, blue} of entry `pix_i` (red in bits 23:16, blue in bits 7:0), registered one cycle after `pix_i` is sampled.
- R10: If a colour byte is written and the same entry is looked up in the same cycle, the lookup returns the value the entry held before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Byte offset within the register window |
| wdata_i | input | 32 | Write data |
| size_i | input | 1 | Write size: 0 = byte, 1 = 32-bit word |
| rdata_o | output | 32 | Register read data (always zero) |
| pix_i | input | 8 | Pixel code for palette lookup |
| pix_rgb_o | output | 24 | Looked-up colour {R, G, B} |
| pal_dirty_o | output | 1 | One-cycle strobe after a colour-data write |

## Verification
The sequencer properties assume that a write never targets both registers in the same cycle. The address decode guarantees this, and the bench issues exactly one write per cycle. The word-write property is checked only for a word that starts on red, and only when the data word is four bytes wide; the bench covers the other starting phases through its scoreboard. Lookups are assumed to hold `pix_i` steady across the sampling edge, so the stimulus changes `pix_i` and all bus inputs on falling edges only.

// File: rtl/clut_pkg.sv
package clut_pkg;
  typedef enum logic [1:0] {
    CH_RED = 2'd0,
    CH_GRN = 2'd1,
    CH_BLU = 2'd2
  } chan_e;

  localparam int REG_IDX_OFS = 0;
  localparam int REG_DAT_OFS = 4;
  localparam int BYTE_W      = 8;
endpackage

// File: rtl/clut_decode.sv
module clut_decode #(
  parameter int ADDR_W = 5
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              size_i,
  output logic              idx_wr_o,
  output logic              dat_wr_o,
  output logic              word_o
);
  import clut_pkg::*;

  assign idx_wr_o = wr_en_i && (addr_i == ADDR_W'(REG_IDX_OFS));
  assign dat_wr_o = wr_en_i && (addr_i == ADDR_W'(REG_DAT_OFS));
  assign word_o   = size_i;
endmodule

// File: rtl/clut_seq.sv
module clut_seq #(
  parameter int IDX_W = 8,
  parameter int LANES = 4
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               idx_wr_i,
  input  logic                               dat_wr_i,
  input  logic                               word_i,
  input  logic [IDX_W-1:0]                   idx_val_i,
  input  logic [LANES*clut_pkg::BYTE_W-1:0]  bytes_i,
  output logic [LANES-1:0]                   lane_vld_o,
  output logic [LANES-1:0][1:0]              lane_ch_o,
  output logic [LANES-1:0][IDX_W-1:0]        lane_idx_o,
  output logic [LANES-1:0][clut_pkg::BYTE_W-1:0] lane_val_o,
  output logic                               dirty_o
);
  import clut_pkg::*;

  chan_e            ch_q, ch_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             dirty_q;

  // Walk the byte lanes in delivery order, each lane seeing the phase the previous one left
  always_comb begin
    chan_e            c;
    logic [IDX_W-1:0] ix;
    c  = ch_q;
    ix = idx_q;
    for (int l = 0; l < LANES; l++) begin
      lane_vld_o[l] = dat_wr_i && (word_i || (l == 0));
      lane_val_o[l] = word_i ? bytes_i[(LANES-1-l)*BYTE_W +: BYTE_W]
                             : ((l == 0) ? bytes_i[BYTE_W-1:0] : '0);
      lane_ch_o[l]  = c;
      lane_idx_o[l] = ix;
      if (lane_vld_o[l]) begin
        if (c == CH_BLU) begin
          c  = CH_RED;
          ix = ix + IDX_W'(1);
        end else begin
          c = chan_e'(c + 2'd1);
        end
      end
    end
    ch_d  = c;
    idx_d = ix;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ch_q    <= CH_RED;
      idx_q   <= '0;
      dirty_q <= 1'b0;
    end else begin
      dirty_q <= dat_wr_i;
      if (idx_wr_i) begin
        ch_q  <= CH_RED;
        idx_q <= idx_val_i;
      end else if (dat_wr_i) begin
        ch_q  <= ch_d;
        idx_q <= idx_d;
      end
    end
  end

  assign dirty_o = dirty_q;

  assert_idx_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_wr_i |=> (ch_q == CH_RED && idx_q == $past(idx_val_i)));

  assert_red_to_green_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_wr_i && !word_i && ch_q == CH_RED) |=> (ch_q == CH_GRN && $stable(idx_q)));

  assert_blue_steps_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_wr_i && !word_i && ch_q == CH_BLU) |=>
      (ch_q == CH_RED && idx_q == $past(idx_q) + IDX_W'(1)));

  assert_dirty_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dat_wr_i |=> dirty_o);

  assert_dirty_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dat_wr_i |=> !dirty_o);

  generate
    if (LANES == 4) begin : g_word4_chk
      assert_word_from_red_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dat_wr_i && word_i && ch_q == CH_RED) |=>
          (ch_q == CH_GRN && idx_q == $past(idx_q) + IDX_W'(1)));
    end
  endgenerate
endmodule

// File: rtl/clut_store.sv
module clut_store #(
  parameter int IDX_W = 8,
  parameter int LANES = 4
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic [LANES-1:0]                       lane_vld_i,
  input  logic [LANES-1:0][1:0]                  lane_ch_i,
  input  logic [LANES-1:0][IDX_W-1:0]            lane_idx_i,
  input  logic [LANES-1:0][clut_pkg::BYTE_W-1:0] lane_val_i,
  input  logic [IDX_W-1:0]                       pix_i,
  output logic [3*clut_pkg::BYTE_W-1:0]          rgb_o
);
  import clut_pkg::*;

  localparam int ENTRIES = 1 << IDX_W;

  logic [BYTE_W-1:0] mem_r [ENTRIES];
  logic [BYTE_W-1:0] mem_g [ENTRIES];
  logic [BYTE_W-1:0] mem_b [ENTRIES];
  logic [3*BYTE_W-1:0] rgb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < ENTRIES; e++) begin
        mem_r[e] <= '0;
        mem_g[e] <= '0;
        mem_b[e] <= '0;
      end
    end else begin
      for (int l = 0; l < LANES; l++) begin
        if (lane_vld_i[l]) begin
          case (chan_e'(lane_ch_i[l]))
            CH_RED:  mem_r[lane_idx_i[l]] <= lane_val_i[l];
            CH_GRN:  mem_g[lane_idx_i[l]] <= lane_val_i[l];
            default: mem_b[lane_idx_i[l]] <= lane_val_i[l];
          endcase
        end
      end
    end
  end

  // Registered read sees pre-edge contents: a colliding write is not forwarded
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rgb_q <= '0;
    else         rgb_q <= {mem_r[pix_i], mem_g[pix_i], mem_b[pix_i]};
  end

  assign rgb_o = rgb_q;

  assert_reset_black_R7: assert property (@(posedge clk_i)
    !rst_ni |-> (rgb_o == '0));
endmodule

// File: rtl/clut_writer.sv
module clut_writer #(
  parameter int ADDR_W = 5,
  parameter int IDX_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              size_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [IDX_W-1:0]  pix_i,
  output logic [23:0]       pix_rgb_o,
  output logic              pal_dirty_o
);
  import clut_pkg::*;

  localparam int LANES = DATA_W / BYTE_W;

  logic                             idx_wr, dat_wr, word;
  logic [LANES-1:0]                 lane_vld;
  logic [LANES-1:0][1:0]            lane_ch;
  logic [LANES-1:0][IDX_W-1:0]      lane_idx;
  logic [LANES-1:0][BYTE_W-1:0]     lane_val;

  clut_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .size_i   (size_i),
    .idx_wr_o (idx_wr),
    .dat_wr_o (dat_wr),
    .word_o   (word)
  );

  clut_seq #(.IDX_W(IDX_W), .LANES(LANES)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .idx_wr_i   (idx_wr),
    .dat_wr_i   (dat_wr),
    .word_i     (word),
    .idx_val_i  (wdata_i[IDX_W-1:0]),
    .bytes_i    (wdata_i[LANES*BYTE_W-1:0]),
    .lane_vld_o (lane_vld),
    .lane_ch_o  (lane_ch),
    .lane_idx_o (lane_idx),
    .lane_val_o (lane_val),
    .dirty_o    (pal_dirty_o)
  );

  clut_store #(.IDX_W(IDX_W), .LANES(LANES)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lane_vld_i (lane_vld),
    .lane_ch_i  (lane_ch),
    .lane_idx_i (lane_idx),
    .lane_val_i (lane_val),
    .pix_i      (pix_i),
    .rgb_o      (pix_rgb_o)
  );

  // Both palette registers are write-only
  assign rdata_o = '0;
endmodule

// File: tb/clut_writer_test.sv
module clut_writer_test;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic        size_i = 1'b0;
  logic [31:0] rdata_o;
  logic [7:0]  pix_i = '0;
  logic [23:0] pix_rgb_o;
  logic        pal_dirty_o;

  clut_writer uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .size_i(size_i), .rdata_o(rdata_o), .pix_i(pix_i),
    .pix_rgb_o(pix_rgb_o), .pal_dirty_o(pal_dirty_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int n_cmp = 0;
  int n_bad = 0;
  logic [23:0] exp_q [$];
  string       tag_q [$];
  logic        look_pend = 1'b0;

  logic [7:0] m_r [256];
  logic [7:0] m_g [256];
  logic [7:0] m_b [256];
  int m_idx, m_ch;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int e = 0; e < 256; e++) begin
      m_r[e] = '0; m_g[e] = '0; m_b[e] = '0;
    end
    m_idx = 0;
    m_ch  = 0;
  endtask

  task automatic model_byte(logic [7:0] v);
    case (m_ch)
      0: begin m_r[m_idx] = v; m_ch = 1; end
      1: begin m_g[m_idx] = v; m_ch = 2; end
      default: begin m_b[m_idx] = v; m_ch = 0; m_idx = (m_idx + 1) % 256; end
    endcase
  endtask

  task automatic model_write(logic [4:0] a, logic [31:0] d, logic sz);
    if (a == 5'h00) begin
      m_idx = int'(d[7:0]);
      m_ch  = 0;
    end else if (a == 5'h04) begin
      if (sz) for (int k = 3; k >= 0; k--) model_byte(d[k*8 +: 8]);
      else    model_byte(d[7:0]);
    end
  endtask

  // Driver: called at a falling edge, returns at the next falling edge
  task automatic wr(logic [4:0] a, logic [31:0] d, logic sz);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d; size_i = sz;
    model_write(a, d, sz);
    @(negedge clk_i);
    wr_en_i = 1'b0;
    chk("R8 dirty strobe", {31'd0, pal_dirty_o}, {31'd0, a == 5'h04});
  endtask

  task automatic push_look(logic [7:0] p, string tag);
    pix_i = p;
    exp_q.push_back({m_r[p], m_g[p], m_b[p]});
    tag_q.push_back(tag);
    look_pend = 1'b1;
  endtask

  task automatic look(logic [7:0] p, string tag);
    push_look(p, tag);
    @(negedge clk_i);
  endtask

  // Write and lookup in the same cycle: expected captured before the model update
  task automatic wr_look(logic [7:0] p, logic [31:0] d, string tag);
    push_look(p, tag);
    wr_en_i = 1'b1; addr_i = 5'h04; wdata_i = d; size_i = 1'b0;
    model_write(5'h04, d, 1'b0);
    @(negedge clk_i);
    wr_en_i = 1'b0;
    chk("R8 dirty strobe", {31'd0, pal_dirty_o}, 32'd1);
  endtask

  // Monitor: result registered at the edge after the request, compared at the next falling edge
  initial begin
    forever begin
      @(posedge clk_i);
      if (look_pend) begin
        logic [23:0] e;
        string t;
        look_pend = 1'b0;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        @(negedge clk_i);
        chk(t, {8'd0, pix_rgb_o}, {8'd0, e});
      end
    end
  end

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk_i);
    chk("R7 reset colour", {8'd0, pix_rgb_o}, 32'd0);
    chk("R8 no strobe in reset", {31'd0, pal_dirty_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R6 rdata zero", rdata_o, 32'd0);
    look(8'h00, "R7 entry 00 cleared");
    look(8'hFF, "R7 entry FF cleared");
    look(8'h80, "R7 entry 80 cleared");

    // R2 R3 R4: byte sequence and step to next entry
    wr(5'h00, 32'h0000_0010, 1'b0);
    wr(5'h04, 32'h0000_0011, 1'b0);
    wr(5'h04, 32'h0000_0022, 1'b0);
    wr(5'h04, 32'h0000_0033, 1'b0);
    wr(5'h04, 32'h0000_0044, 1'b0);
    look(8'h10, "R3 R,G,B into entry 10");
    look(8'h11, "R4 step after blue");
    chk("R8 quiet when idle", {31'd0, pal_dirty_o}, 32'd0);

    // R2: index write mid-entry restarts at red
    wr(5'h00, 32'h0000_0020, 1'b0);
    wr(5'h04, 32'h0000_00AA, 1'b0);
    wr(5'h04, 32'h0000_00BB, 1'b0);
    wr(5'h00, 32'h0000_0021, 1'b0);
    wr(5'h04, 32'h0000_00CC, 1'b0);
    look(8'h20, "R2 partial entry kept");
    look(8'h21, "R2 restart at red");

    // R4: wrap from FF to 00
    wr(5'h00, 32'h0000_00FF, 1'b0);
    wr(5'h04, 32'h0000_0001, 1'b0);
    wr(5'h04, 32'h0000_0002, 1'b0);
    wr(5'h04, 32'h0000_0003, 1'b0);
    wr(5'h04, 32'h0000_0009, 1'b0);
    look(8'hFF, "R4 entry FF");
    look(8'h00, "R4 wrap to entry 00");

    // R5: word writes from each starting phase, byte write uses low lane
    wr(5'h00, 32'h0000_0040, 1'b0);
    wr(5'h04, 32'h0102_0304, 1'b1);
    wr(5'h04, 32'h0506_0708, 1'b1);
    look(8'h40, "R5 word from red");
    look(8'h41, "R5 word from green");
    look(8'h42, "R5 word tail");
    wr(5'h00, 32'h0000_0050, 1'b0);
    wr(5'h04, 32'h0000_0001, 1'b0);
    wr(5'h04, 32'h0000_0002, 1'b0);
    wr(5'h04, 32'h0A0B_0C0D, 1'b1);
    wr(5'h04, 32'hDEAD_BE77, 1'b0);
    look(8'h50, "R5 word from blue first entry");
    look(8'h51, "R5 word from blue second entry");
    look(8'h52, "R5 byte write low lane");

    // R1: other offsets ignored, sequence continues
    wr(5'h00, 32'h0000_0060, 1'b0);
    wr(5'h04, 32'h0000_0061, 1'b0);
    wr(5'h08, 32'h0000_00F0, 1'b0);
    wr(5'h10, 32'h0000_0070, 1'b0);
    wr(5'h05, 32'h0000_00F1, 1'b0);
    wr(5'h04, 32'h0000_0062, 1'b0);
    wr(5'h04, 32'h0000_0063, 1'b0);
    look(8'h60, "R1 stray offsets ignored");
    look(8'h70, "R1 stray index untouched");
    look(8'h61, "R1 pointer unchanged");
    chk("R6 rdata zero after writes", rdata_o, 32'd0);

    // R10: same-cycle write and lookup of one entry
    wr(5'h00, 32'h0000_0090, 1'b0);
    wr_look(8'h90, 32'h0000_0055, "R10 old value on collision");
    look(8'h90, "R9 new value next cycle");
    look(8'h10, "R9 unrelated entry");

    // R7: reset mid-run clears everything
    @(negedge clk_i);
    rst_ni = 1'b0;
    model_reset();
    @(negedge clk_i);
    chk("R7 output cleared", {8'd0, pix_rgb_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    look(8'h10, "R7 entry 10 cleared");
    look(8'h51, "R7 entry 51 cleared");
    wr(5'h04, 32'h0000_00E1, 1'b0);
    look(8'h00, "R7 pointer 00 sequencer red");

    repeat (3) @(negedge clk_i);
    finish_run();
  end
endmodule